// File: doc/BRIEF.md
# Buzzer and Divided-Clock Output Port

This block forms the logic levels for three output pins of a small controller from three register bits and a set of static option inputs. Pin A is a plain level output or a gated buzzer output. Pin C is a plain level output, its own gated buzzer output, or the complement of the pin A buzzer waveform. Pin B is a plain level output or a gated square-wave clock. That clock is a tap of a free-running divider, and a 3-bit code selects which tap is used.

The divider advances once for each cycle where `base_tick` is high. In a real system `base_tick` strobes at twice the top clock-output rate, so tap 0 gives the top rate and each higher code halves it. The buzzer tone is an ordinary level input from a tone generator elsewhere. The pad stage is modelled only as a per-pin output enable: a complementary pin is always driven, and an open-drain pin is driven only while its value is high.

All pins are plain control signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `buzz_clk_port`

## Requirements
- R1: When `cfg_a_buzz` is 0, `pin_a` equals `reg_a`.
- R2: When `cfg_a_buzz` is 1, `pin_a` equals `tone` while `reg_a` is 1, and it is low while `reg_a` is 0.
- R3: `cfg_c_mode` selects pin C behaviour. Code 0 is a level output (`pin_c` = `reg_c`). Code 1 is its own buzzer (`reg_c` AND `tone`). Code 2 is the inverted buzzer (`reg_c` AND NOT `tone`), so while `reg_a` and `reg_c` are both 1 it is the complement of `pin_a`. Code 3 behaves as code 0.
- R4: When `cfg_a_buzz` is 0, codes 1 and 2 on `cfg_c_mode` are coerced to the level output, so `pin_c` = `reg_c`.
- R5: When `cfg_b_clk` is 0, `pin_b` equals `reg_b`.
- R6: A divider counter, 2^SEL_W bits wide, resets to 0 and increments at every clock edge where `base_tick` is 1. In clock mode with the gate open, `pin_b` is counter bit `cfg_b_sel`. The result is a 50% duty square wave with a period of 2^(sel+1) ticks, and code 0 is the fastest.
- R7: In clock mode, the gate takes the value of `reg_b` only at clock edges where the selected tap was low before the edge. While the gate is closed, `pin_b` is low. Opening or closing the gate never shortens a high phase.
- R8: After reset the divider is 0 and the gate is closed, so `pin_b` is low in clock mode.
- R9: Output enables are `pin_oe[0]` for A, `pin_oe[1]` for B and `pin_oe[2]` for C. With `cfg_od[i]` = 0 the enable is 1. With `cfg_od[i]` = 1 it equals the pin's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | Divider advance strobe |
| tone | input | 1 | Buzzer tone waveform |
| reg_a | input | 1 | Register bit for pin A |
| reg_b | input | 1 | Register bit for pin B |
| reg_c | input | 1 | Register bit for pin C |
| cfg_a_buzz | input | 1 | Pin A buzzer mode |
| cfg_b_clk | input | 1 | Pin B clock-output mode |
| cfg_b_sel | input | SEL_W | Clock tap code |
| cfg_c_mode | input | 2 | Pin C mode code |
| cfg_od | input | 3 | Open-drain select per pin |
| pin_a | output | 1 | Pin A level |
| pin_b | output | 1 | Pin B level |
| pin_c | output | 1 | Pin C level |
| pin_oe | output | 3 | Pad drive enables |

## Verification
The divider tick and a change of `reg_b` can land in the same cycle, including the edge where the selected tap rises. Only the tap value before the edge decides whether the gate follows, so a gate update and a rising tap together must give a full high phase. The bench provokes this case. For every tap code it runs a tick pattern with gaps and toggles `reg_b` part-way through high and low phases. It judges every cycle against an arithmetic model of the count and the gate. The bench also sweeps every combination of buzzer modes, register bits, tone level and open-drain selects.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
  typedef enum logic [1:0] {
    C_LEVEL = 2'd0,
    C_TONE  = 2'd1,
    C_INV   = 2'd2,
    C_RSV   = 2'd3
  } c_mode_e;
  localparam int unsigned NPINS = 3;
endpackage

// File: rtl/tone_route.sv
module tone_route
  import bcp_pkg::*;
(
  input  logic       buzz_a,
  input  logic [1:0] mode_c,
  input  logic       reg_a,
  input  logic       reg_c,
  input  logic       tone,
  output logic       val_a,
  output logic       val_c
);
  c_mode_e eff_c;

  always_comb begin
    eff_c = c_mode_e'(mode_c);
    // tone-based modes on C need A in buzzer mode; reserved code acts as level
    if (!buzz_a || eff_c == C_RSV) eff_c = C_LEVEL;
  end

  always_comb begin
    val_a = buzz_a ? (reg_a & tone) : reg_a;
    unique case (eff_c)
      C_TONE:  val_c = reg_c & tone;
      C_INV:   val_c = reg_c & ~tone;
      default: val_c = reg_c;
    endcase
  end
endmodule

// File: rtl/fout_divider.sv
module fout_divider #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tap
);
  localparam int unsigned CNT_W = 1 << SEL_W;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign tap = cnt_q[sel];
endmodule

// File: rtl/fout_gate.sv
module fout_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tap,
  input  logic clk_mode,
  input  logic reg_b,
  output logic val_b
);
  logic gate_q;

  // gate moves only while the tap sits low, so no high phase is cut
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gate_q <= 1'b0;
    else if (!tap) gate_q <= clk_mode & reg_b;
  end

  assign val_b = clk_mode ? (gate_q & tap) : reg_b;
endmodule

// File: rtl/pad_enable.sv
module pad_enable #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] val,
  input  logic [N-1:0] od,
  output logic [N-1:0] oe
);
  for (genvar i = 0; i < N; i++) begin : g_pad
    assign oe[i] = od[i] ? val[i] : 1'b1;
  end
endmodule

// File: rtl/buzz_clk_port.sv
module buzz_clk_port
  import bcp_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             tone,
  input  logic             reg_a,
  input  logic             reg_b,
  input  logic             reg_c,
  input  logic             cfg_a_buzz,
  input  logic             cfg_b_clk,
  input  logic [SEL_W-1:0] cfg_b_sel,
  input  logic [1:0]       cfg_c_mode,
  input  logic [NPINS-1:0] cfg_od,
  output logic             pin_a,
  output logic             pin_b,
  output logic             pin_c,
  output logic [NPINS-1:0] pin_oe
);
  logic tap;

  tone_route u_route (
    .buzz_a (cfg_a_buzz),
    .mode_c (cfg_c_mode),
    .reg_a  (reg_a),
    .reg_c  (reg_c),
    .tone   (tone),
    .val_a  (pin_a),
    .val_c  (pin_c)
  );

  fout_divider #(.SEL_W(SEL_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (base_tick),
    .sel   (cfg_b_sel),
    .tap   (tap)
  );

  fout_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .tap      (tap),
    .clk_mode (cfg_b_clk),
    .reg_b    (reg_b),
    .val_b    (pin_b)
  );

  pad_enable #(.N(NPINS)) u_pad (
    .val ({pin_c, pin_b, pin_a}),
    .od  (cfg_od),
    .oe  (pin_oe)
  );
endmodule

// File: rtl/buzz_clk_port_chk.sv
module buzz_clk_port_chk #(
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             base_tick,
  input logic             reg_a,
  input logic             reg_b,
  input logic             reg_c,
  input logic             cfg_a_buzz,
  input logic             cfg_b_clk,
  input logic [SEL_W-1:0] cfg_b_sel,
  input logic [1:0]       cfg_c_mode,
  input logic [2:0]       cfg_od,
  input logic             pin_a,
  input logic             pin_b,
  input logic             pin_c,
  input logic [2:0]       pin_oe
);
  p_level_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_a_buzz |-> pin_a == reg_a);

  p_inverse_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_a_buzz && cfg_c_mode == 2'd2 && reg_a && reg_c) |-> pin_c != pin_a);

  p_coerce_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_a_buzz |-> pin_c == reg_c);

  p_rise_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pin_b) && cfg_b_clk && $past(cfg_b_clk) && $stable(cfg_b_sel))
      |-> $past(base_tick));

  p_fall_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pin_b) && cfg_b_clk && $past(cfg_b_clk) && $stable(cfg_b_sel))
      |-> $past(base_tick));

  p_closed_stays_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_b_clk && $past(cfg_b_clk) && !$past(reg_b) && !$past(pin_b)
      && $stable(cfg_b_sel)) |-> !pin_b);

  p_od_low_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pin_oe & ~cfg_od) == $countones(~cfg_od)
    && !(cfg_od[1] && !pin_b && pin_oe[1]));
endmodule

bind buzz_clk_port buzz_clk_port_chk #(.SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .base_tick  (base_tick),
  .reg_a      (reg_a),
  .reg_b      (reg_b),
  .reg_c      (reg_c),
  .cfg_a_buzz (cfg_a_buzz),
  .cfg_b_clk  (cfg_b_clk),
  .cfg_b_sel  (cfg_b_sel),
  .cfg_c_mode (cfg_c_mode),
  .cfg_od     (cfg_od),
  .pin_a      (pin_a),
  .pin_b      (pin_b),
  .pin_c      (pin_c),
  .pin_oe     (pin_oe)
);

// File: tb/buzz_clk_port_tb.sv
module buzz_clk_port_tb;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned CNT_W = 1 << SEL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_tick = 1'b0, tone = 1'b0;
  logic reg_a = 1'b0, reg_b = 1'b0, reg_c = 1'b0;
  logic cfg_a_buzz = 1'b0, cfg_b_clk = 1'b0;
  logic [SEL_W-1:0] cfg_b_sel = '0;
  logic [1:0] cfg_c_mode = 2'd0;
  logic [2:0] cfg_od = 3'd0;
  logic pin_a, pin_b, pin_c;
  logic [2:0] pin_oe;

  int n_cmp = 0, n_bad = 0;
  logic [CNT_W-1:0] m_cnt = '0;
  logic m_gate = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  buzz_clk_port #(.SEL_W(SEL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .tone(tone),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
    .cfg_a_buzz(cfg_a_buzz), .cfg_b_clk(cfg_b_clk), .cfg_b_sel(cfg_b_sel),
    .cfg_c_mode(cfg_c_mode), .cfg_od(cfg_od),
    .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c), .pin_oe(pin_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_a();
    return cfg_a_buzz ? (reg_a & tone) : reg_a;
  endfunction

  function automatic logic exp_c();
    if (!cfg_a_buzz || cfg_c_mode == 2'd0 || cfg_c_mode == 2'd3) return reg_c;
    if (cfg_c_mode == 2'd1) return reg_c & tone;
    return reg_c & ~tone;
  endfunction

  function automatic logic exp_b();
    return cfg_b_clk ? (m_gate & m_cnt[cfg_b_sel]) : reg_b;
  endfunction

  // one clock: inputs already set away from the edge; model follows the edge
  task automatic step(input logic tk);
    logic [2:0] ev, eoe;
    base_tick = tk;
    @(posedge clk);
    if (!m_cnt[cfg_b_sel]) m_gate = cfg_b_clk & reg_b;
    if (tk) m_cnt = m_cnt + 1'b1;
    #2;
    ev = {exp_c(), exp_b(), exp_a()};
    for (int i = 0; i < 3; i++) eoe[i] = cfg_od[i] ? ev[i] : 1'b1;
    check(pin_a == ev[0], cfg_a_buzz ? "R2 pin_a" : "R1 pin_a", pin_a, ev[0]);
    check(pin_c == ev[2], cfg_a_buzz ? "R3 pin_c" : "R4 pin_c", pin_c, ev[2]);
    check(pin_b == ev[1], cfg_b_clk ? "R6/R7 pin_b" : "R5 pin_b", pin_b, ev[1]);
    check(pin_oe == eoe, "R9 pin_oe", pin_oe, eoe);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      check(1'b0, "R8 watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cfg_b_clk = 1'b1; reg_b = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(pin_b == 1'b0, "R8 reset pin_b", pin_b, 0);
    rst_n = 1'b1;
    cfg_b_clk = 1'b0; reg_b = 1'b0;
    m_cnt = '0; m_gate = 1'b0;
    step(1'b0);
    check(pin_b == 1'b0, "R8 post-reset pin_b", pin_b, 0);

    // sweep of routing, level and drive-enable combinations
    for (int v = 0; v < 1024; v++) begin
      {cfg_od, cfg_c_mode, cfg_a_buzz, reg_a, reg_c, reg_b, tone} = 10'(v);
      step(1'b0);
    end

    // level mode on B with a running divider
    cfg_od = 3'b010;
    for (int i = 0; i < 16; i++) begin
      reg_b = i[1];
      step(i[0]);
    end

    // clock mode on every tap, with gated ticks and gate toggles
    for (int s = 0; s < (1 << SEL_W); s++) begin
      cfg_b_clk = 1'b0; reg_b = 1'b0;
      cfg_b_sel = SEL_W'(s);
      cfg_od = 3'(s);
      step(1'b0);
      cfg_b_clk = 1'b1;
      reg_b = 1'b1;
      for (int i = 0; i < (8 << s) + 40; i++) begin
        if (i % 7 == 3 || i % 11 == 5) reg_b = ~reg_b;
        step(i % 3 != 2);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule